// File: doc/BRIEF.md
# I2C SCL Clock Generator with Prescaler

This block derives the SCL waveform of an I2C master from the system clock. A prescaler divides the system clock into a module-clock enable (`mod_tick`). SCL then alternates between a low phase and a high phase. Each phase lasts a programmed divider value plus a small fixed extra count, measured in module ticks. The extra count depends on the prescaler setting. A build parameter can pin it to a single constant instead.

The generator is held idle while `core_en` is low. During that time the prescaler value is captured, and it stays frozen once `core_en` rises. The low and high dividers are read afresh at every phase boundary, so a write in the middle of a phase only affects the next phase. `run` requests clocking: SCL idles high and begins with a low phase. A zero high divider stops clock generation entirely. A one-cycle `sample_stb` marks the middle of every high phase, for use as a data sample point.

Top module: `scl_clkgen`

## Requirements
- R1: While `core_en` is 0, `scl_o` is high and `mod_tick` and `sample_stb` are 0; after reset the same holds.
- R2: While `core_en` is 1, `mod_tick` pulses for one cycle every P+1 system cycles, where P is the captured prescaler value.
- R3: Each SCL low phase lasts (`div_lo` + d) × (P+1) system cycles.
- R4: Each SCL high phase between two low phases lasts (`div_hi` + d) × (P+1) system cycles.
- R5: With the default build, d is 7 when P = 0, 6 when P = 1, and 5 when P ≥ 2.
- R6: With `FIXED_D6` = 1, d is 6 for every P.
- R7: While `div_hi` is 0, no low phase starts and `scl_o` stays high even with `run` = 1.
- R8: Before `run` is asserted SCL is high and the first change is a fall; after `run` drops, the current high phase ends and SCL stays high with no further low phase.
- R9: A change of `psc_in` while `core_en` is 1 has no effect on tick spacing or phase lengths until `core_en` has been 0 for at least one cycle.
- R10: A change of `div_lo` during a low phase leaves that phase's length unchanged; the next low phase uses the new value.
- R11: `sample_stb` pulses exactly once per high phase. It pulses together with the ceil(L/2)-th `mod_tick` counted from the SCL rise, where L = `div_hi` + d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_en | input | 1 | 0 holds the generator idle and captures the prescaler |
| run | input | 1 | Request for SCL clocking |
| psc_in | input | PSC_W | Prescaler value P (module clock = clk / (P+1)) |
| div_lo | input | DIV_W | Low-phase divider |
| div_hi | input | DIV_W | High-phase divider; 0 suppresses clocking |
| scl_o | output | 1 | SCL level (1 = released high) |
| mod_tick | output | 1 | Module-clock enable pulse |
| sample_stb | output | 1 | Pulse at the middle of each high phase |

## Verification
SCL changes one system cycle after the edge at which `mod_tick` is high and a phase counter reaches zero. Phase widths are therefore counted as the number of falling-edge samples between two observed transitions, and each should equal a whole multiple of P+1. The strobe is combinational with the tick, so its position is checked by counting ticks seen with SCL high since the rise, in the same sample that shows the strobe. Inputs change one time unit after a rising edge, and outputs are read on the falling edge, so no result depends on process order. Configuration changes are judged only after two or more complete phases have been observed, so any partial phase left by a change is discarded.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Fixed extra module ticks added to each SCL phase.
  function automatic int unsigned extra_count(input int unsigned psc, input bit fixed6);
    if (fixed6)        return 6;
    else if (psc == 0) return 7;
    else if (psc == 1) return 6;
    else               return 5;
  endfunction

  // Tick index within a high phase (counted from 1) at which the strobe fires.
  function automatic int unsigned mid_tick(input int unsigned len);
    return (len + 1) / 2;
  endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_en,
  input  logic [PSC_W-1:0] psc_in,
  output logic [PSC_W-1:0] psc_q,
  output logic             tick
);

  logic [PSC_W-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q   <= '0;
      div_cnt <= '0;
    end else if (!core_en) begin
      psc_q   <= psc_in;
      div_cnt <= '0;
    end else if (div_cnt == psc_q) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + PSC_W'(1);
    end
  end

  assign tick = core_en && (div_cnt == psc_q);

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_clkgen_pkg::*;
#(
  parameter int PSC_W    = 8,
  parameter int DIV_W    = 8,
  parameter int FIXED_D6 = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_en,
  input  logic             run,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc_q,
  input  logic [DIV_W-1:0] div_lo,
  input  logic [DIV_W-1:0] div_hi,
  output logic             scl_o,
  output logic             sample_stb,
  output logic             phase_end
);

  localparam int LEN_W = DIV_W + 1;

  scl_phase_e       ph;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] mid;
  logic [LEN_W-1:0] d_val;
  logic [LEN_W-1:0] lo_len;
  logic [LEN_W-1:0] hi_len;
  logic             hi_ok;

  assign d_val     = LEN_W'(extra_count(32'(psc_q), FIXED_D6 != 0));
  assign lo_len    = {1'b0, div_lo} + d_val;
  assign hi_len    = {1'b0, div_hi} + d_val;
  assign hi_ok     = (div_hi != '0);
  assign phase_end = tick && (ph != PH_IDLE) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
      mid <= '0;
    end else if (!core_en) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (tick) begin
      unique case (ph)
        PH_IDLE: begin
          if (run && hi_ok) begin
            ph  <= PH_LOW;
            cnt <= lo_len - LEN_W'(1);
          end
        end
        PH_LOW: begin
          if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
          end else if (hi_ok) begin
            ph  <= PH_HIGH;
            cnt <= hi_len - LEN_W'(1);
            mid <= hi_len >> 1;
          end else begin
            ph <= PH_IDLE;
          end
        end
        PH_HIGH: begin
          if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
          end else if (run && hi_ok) begin
            ph  <= PH_LOW;
            cnt <= lo_len - LEN_W'(1);
          end else begin
            ph <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign scl_o      = (ph != PH_LOW);
  assign sample_stb = (ph == PH_HIGH) && tick && (cnt == mid);

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int PSC_W    = 8,
  parameter int DIV_W    = 8,
  parameter int FIXED_D6 = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_en,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [DIV_W-1:0] div_lo,
  input  logic [DIV_W-1:0] div_hi,
  output logic             scl_o,
  output logic             mod_tick,
  output logic             sample_stb
);

  logic [PSC_W-1:0] psc_q_w;
  logic             phase_end_w;

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .core_en (core_en),
    .psc_in  (psc_in),
    .psc_q   (psc_q_w),
    .tick    (mod_tick)
  );

  scl_phase_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .FIXED_D6(FIXED_D6)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_en    (core_en),
    .run        (run),
    .tick       (mod_tick),
    .psc_q      (psc_q_w),
    .div_lo     (div_lo),
    .div_hi     (div_hi),
    .scl_o      (scl_o),
    .sample_stb (sample_stb),
    .phase_end  (phase_end_w)
  );

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
  parameter int PSC_W = 8,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_en,
  input logic [DIV_W-1:0] div_hi,
  input logic             scl_o,
  input logic             mod_tick,
  input logic             sample_stb,
  input logic             phase_end,
  input logic [PSC_W-1:0] psc_q
);

  // R1: holding core_en low releases SCL high on the next cycle
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> scl_o);

  // R3: SCL only moves on a module tick
  a_r3_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !mod_tick) |=> $stable(scl_o));

  // R4: SCL leaves a phase only when that phase's counter expires
  a_r4_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !scl_o && !phase_end) |=> !scl_o);

  // R7: a zero high divider never lets SCL fall
  a_r7_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && scl_o && div_hi == '0) |=> scl_o);

  // R9: the captured prescaler is frozen while enabled
  a_r9_psc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && $past(core_en)) |-> $stable(psc_q));

  // R11: the strobe comes with a tick while SCL is high
  a_r11_stb_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (scl_o && mod_tick));

endmodule

bind scl_clkgen scl_clkgen_chk #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_en    (core_en),
  .div_hi     (div_hi),
  .scl_o      (scl_o),
  .mod_tick   (mod_tick),
  .sample_stb (sample_stb),
  .phase_end  (phase_end_w),
  .psc_q      (psc_q_w)
);

// File: tb/scl_clkgen_tb_top.sv
`timescale 1ns/1ps

module scl_clkgen_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic tick,
  input  logic stb,
  output int   lo_w,
  output int   hi_w,
  output int   lo_n,
  output int   hi_n,
  output int   gap,
  output int   stb_pos,
  output int   stb_cnt
);
  int  run_len, cyc, last_tick, htick, stb_in;
  logic prev;

  always @(negedge clk) begin
    if (!rst_n) begin
      lo_w = 0; hi_w = 0; lo_n = 0; hi_n = 0; gap = 0; stb_pos = 0; stb_cnt = 0;
      run_len = 0; cyc = 0; last_tick = 0; htick = 0; stb_in = 0; prev = 1'b1;
    end else begin
      cyc++;
      if (scl != prev) begin
        if (!prev) begin
          lo_w = run_len; lo_n++; htick = 0; stb_in = 0;
        end else begin
          hi_w = run_len; hi_n++; stb_cnt = stb_in;
        end
        run_len = 1;
      end else begin
        run_len++;
      end
      prev = scl;
      if (tick) begin
        gap = cyc - last_tick;
        last_tick = cyc;
        if (scl) htick++;
      end
      if (stb) begin
        stb_in++;
        stb_pos = htick;
      end
    end
  end
endmodule

module scl_clkgen_tb_top;
  localparam int PSC_W = 8;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_en = 1'b0;
  logic run = 1'b0;
  logic [PSC_W-1:0] psc_in = '0;
  logic [DIV_W-1:0] div_lo = '0;
  logic [DIV_W-1:0] div_hi = '0;
  logic scl_o, mod_tick, sample_stb;
  logic fx_scl, fx_tick, fx_stb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_lo_w, m_hi_w, m_lo_n, m_hi_n, m_gap, m_stb_pos, m_stb_cnt;
  int f_lo_w, f_hi_w, f_lo_n, f_hi_n, f_gap, f_stb_pos, f_stb_cnt;

  always #5 clk = ~clk;

  scl_clkgen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .FIXED_D6(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .run(run), .psc_in(psc_in),
    .div_lo(div_lo), .div_hi(div_hi), .scl_o(scl_o), .mod_tick(mod_tick),
    .sample_stb(sample_stb));

  scl_clkgen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .FIXED_D6(1)) dut_fix_i (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .run(run), .psc_in(psc_in),
    .div_lo(div_lo), .div_hi(div_hi), .scl_o(fx_scl), .mod_tick(fx_tick),
    .sample_stb(fx_stb));

  scl_clkgen_mon mon_i (.clk(clk), .rst_n(rst_n), .scl(scl_o), .tick(mod_tick),
    .stb(sample_stb), .lo_w(m_lo_w), .hi_w(m_hi_w), .lo_n(m_lo_n), .hi_n(m_hi_n),
    .gap(m_gap), .stb_pos(m_stb_pos), .stb_cnt(m_stb_cnt));

  scl_clkgen_mon mon_fix_i (.clk(clk), .rst_n(rst_n), .scl(fx_scl), .tick(fx_tick),
    .stb(fx_stb), .lo_w(f_lo_w), .hi_w(f_hi_w), .lo_n(f_lo_n), .hi_n(f_hi_n),
    .gap(f_gap), .stb_pos(f_stb_pos), .stb_cnt(f_stb_cnt));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic int exp_d(input int p, input bit fix);
    if (fix) return 6;
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  task automatic wait_main_hi(input int target);
    for (int i = 0; i < 5000 && m_hi_n < target; i++) step(1);
  endtask

  task automatic wait_fix_hi(input int target);
    for (int i = 0; i < 5000 && f_hi_n < target; i++) step(1);
  endtask

  task automatic wait_main_lo(input int target);
    for (int i = 0; i < 5000 && m_lo_n < target; i++) step(1);
  endtask

  task automatic run_cfg(input int p, input int lo, input int hi);
    int d, llo, lhi, fd, mb, fb, n0;
    d  = exp_d(p, 1'b0);
    fd = exp_d(p, 1'b1);
    llo = lo + d;
    lhi = hi + d;
    run = 1'b0;
    core_en = 1'b0;
    psc_in = PSC_W'(p);
    div_lo = DIV_W'(lo);
    div_hi = DIV_W'(hi);
    step(3);
    chk("R1 scl high while held", int'(scl_o), 1);
    chk("R8 idle high before run", int'(scl_o), 1);
    mb = m_hi_n;
    fb = f_hi_n;
    core_en = 1'b1;
    run = 1'b1;
    wait_main_hi(mb + 3);
    wait_fix_hi(fb + 3);
    chk($sformatf("R3 R5 low width p=%0d lo=%0d", p, lo), m_lo_w, llo * (p + 1));
    chk($sformatf("R4 R5 high width p=%0d hi=%0d", p, hi), m_hi_w, lhi * (p + 1));
    chk($sformatf("R2 tick gap p=%0d", p), m_gap, p + 1);
    chk($sformatf("R11 strobe count p=%0d hi=%0d", p, hi), m_stb_cnt, 1);
    chk($sformatf("R11 strobe position p=%0d hi=%0d", p, hi), m_stb_pos, (lhi + 1) / 2);
    chk($sformatf("R6 fixed low width p=%0d", p), f_lo_w, (lo + fd) * (p + 1));
    chk($sformatf("R6 fixed high width p=%0d", p), f_hi_w, (hi + fd) * (p + 1));
    run = 1'b0;
    step(2 * (lo + hi + 14) * (p + 1) + 20);
    n0 = m_lo_n;
    step(40);
    chk("R8 no low phase after run drops", m_lo_n, n0);
    chk("R8 scl high after run drops", int'(scl_o), 1);
  endtask

  initial begin
    int los[3] = '{0, 2, 5};
    int his[2] = '{1, 3};
    int n0;
    step(4);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset scl", int'(scl_o), 1);
    chk("R1 reset tick", int'(mod_tick), 0);
    chk("R1 reset strobe", int'(sample_stb), 0);

    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 2; b++)
          run_cfg(p, los[a], his[b]);

    // R7: zero high divider
    core_en = 1'b0; run = 1'b0;
    psc_in = 8'd0; div_lo = 8'd2; div_hi = 8'd0;
    step(3);
    n0 = m_lo_n;
    core_en = 1'b1; run = 1'b1;
    step(200);
    chk("R7 no low phase with zero high divider", m_lo_n, n0);
    chk("R7 scl stays high", int'(scl_o), 1);

    // R9: prescaler write while enabled
    core_en = 1'b0; run = 1'b0;
    psc_in = 8'd1; div_lo = 8'd1; div_hi = 8'd1;
    step(3);
    core_en = 1'b1; run = 1'b1;
    n0 = m_lo_n;
    wait_main_lo(n0 + 2);
    psc_in = 8'd3;
    n0 = m_lo_n;
    wait_main_lo(n0 + 2);
    chk("R9 low width keeps old prescaler", m_lo_w, 7 * 2);
    chk("R9 tick gap keeps old prescaler", m_gap, 2);
    core_en = 1'b0;
    step(3);
    core_en = 1'b1;
    n0 = m_lo_n;
    wait_main_lo(n0 + 2);
    chk("R9 new prescaler after release", m_lo_w, 6 * 4);

    // R10: low divider write inside a low phase
    core_en = 1'b0; run = 1'b0;
    psc_in = 8'd0; div_lo = 8'd2; div_hi = 8'd2;
    step(3);
    core_en = 1'b1; run = 1'b1;
    n0 = m_lo_n;
    wait_main_lo(n0 + 1);
    for (int i = 0; i < 200 && scl_o; i++) step(1);
    step(2);
    div_lo = 8'd6;
    n0 = m_lo_n;
    wait_main_lo(n0 + 1);
    chk("R10 current low phase unchanged", m_lo_w, 9);
    wait_main_lo(n0 + 2);
    chk("R10 next low phase uses new divider", m_lo_w, 13);

    core_en = 1'b0; run = 1'b0;
    step(2);
    chk("R1 tick off when held", int'(mod_tick), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule